// File: doc/BRIEF.md
# Guest Bus Cycle Sequencer

This block runs access cycles on a small multiplexed peripheral bus that serves eight guest ports. A host-side request names a guest, a 3-bit register address inside that guest, and a direction. For a write it also carries data. The sequencer raises the guest's select line and the strobe, and drives the address and data. It holds the strobe for that guest's programmed duration, then keeps the bus quiet for that guest's programmed recovery time. It then returns to idle.

Each guest has its own 2-bit duration code and its own 2-bit recovery code. Both codes use the same table of clock counts. A single-cycle command input issues a one-shot "go" write cycle to a guest and register address held in a configuration register. That cycle uses the target guest's own timing. The sequencer holds one pending host request and one pending command while a cycle is running, and issues them once the current cycle has fully recovered.

Top module: `guest_bus_seq`

## Requirements
- R1: Guest g's duration code sits in timing-register bits [4g+3:4g+2]. The strobe stays high for exactly 3, 4, 12 or 15 clocks for codes 0, 1, 2 and 3.
- R2: Guest g's recovery code sits in timing-register bits [4g+1:4g] and uses the same table as R1. After the strobe falls, `busy` stays high for exactly that many clocks with no strobe, then drops if nothing is pending.
- R3: While the strobe is high, `gb_cs` has only bit g set, and `gb_cs`, `gb_addr` and `gb_write` stay unchanged. `gb_cs` is all zero whenever the strobe is low.
- R4: On a read, `rd_data` takes the value of `gb_din` from the last clock of the strobe. `rd_valid` pulses for one clock in the cycle after the strobe falls. No pulse follows a write.
- R5: On a write, `gb_dout` carries the request's data for the whole strobe.
- R6: A request sampled with the pending slot empty is accepted. `busy` rises on the next clock, and the strobe first goes high one clock after that.
- R7: A request accepted while a cycle runs is held. Its strobe starts recovery+1 clocks after the running strobe falls, and `busy` stays high throughout.
- R8: A request that arrives while the host pending slot is already occupied is ignored and never produces a strobe.
- R9: A `cmd_go` pulse issues a write of zero data to the guest in command-register bits [6:4] at the address in bits [2:0], using that guest's timing. `cmd_done` pulses for one clock in the first clock after recovery ends.
- R10: The timing register (`cfg_sel`=0) resets to zero. The command register (`cfg_sel`=1) resets to guest 4, address 0, and its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_sel | input | 1 | 0 = timing register, 1 = command register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected configuration register |
| req_valid | input | 1 | Host request, sampled each clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_guest | input | 3 | Target guest |
| req_addr | input | 3 | Register address inside the guest |
| req_wdata | input | 8 | Write data |
| cmd_go | input | 1 | Single-cycle go command |
| gb_cs | output | 8 | One-hot guest select |
| gb_strobe | output | 1 | Access strobe |
| gb_write | output | 1 | Direction of the current cycle |
| gb_addr | output | 3 | Guest register address |
| gb_dout | output | 8 | Data to guest |
| gb_din | input | 8 | Data from guest |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | Read data valid pulse |
| cmd_done | output | 1 | Go cycle complete pulse |
| busy | output | 1 | A cycle is pending or running |

## Verification
A wrong timing code lookup or a miscounting counter shows up at once as a strobe or a `busy` tail of the wrong length. It is visible on the very cycle where that guest is first accessed. The bench sweeps every duration and recovery code on every guest for that reason. A lost or duplicated pending entry shows up within one recovery period, as a missing strobe or an extra one. A wrong capture edge gives the wrong `rd_data` on the first read, because the bench changes `gb_din` on every strobe clock.

// File: rtl/guest_bus_seq.sv
module guest_bus_seq #(
  parameter int NG = 8,
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int CW = 32,
  parameter int CMD_GUEST_RST = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [CW-1:0]         cfg_wdata,
  output logic [CW-1:0]         cfg_rdata,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [$clog2(NG)-1:0] req_guest,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic                  cmd_go,
  output logic [NG-1:0]         gb_cs,
  output logic                  gb_strobe,
  output logic                  gb_write,
  output logic [AW-1:0]         gb_addr,
  output logic [DW-1:0]         gb_dout,
  input  logic [DW-1:0]         gb_din,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_valid,
  output logic                  cmd_done,
  output logic                  busy
);
  localparam int GW = $clog2(NG);
  localparam int TW = 4 * NG;
  localparam int CMD_LSB = 4;

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_RECOVER} state_t;

  function automatic logic [3:0] code_clocks(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd3;
      2'd1:    return 4'd4;
      2'd2:    return 4'd12;
      default: return 4'd15;
    endcase
  endfunction

  logic [TW-1:0] tmg;
  logic [GW-1:0] cmd_guest;
  logic [AW-1:0] cmd_addr;

  state_t        state;
  logic [3:0]    cnt;
  logic [1:0]    cur_rec;
  logic          cur_cmd;
  logic [GW-1:0] cur_guest;

  logic          hp_valid;
  logic          hp_write;
  logic [GW-1:0] hp_guest;
  logic [AW-1:0] hp_addr;
  logic [DW-1:0] hp_wdata;
  logic          cp_valid;

  logic [GW-1:0] nx_guest;
  logic [1:0]    nx_dur;
  logic [1:0]    nx_rec;

  assign nx_guest = cp_valid ? cmd_guest : hp_guest;
  assign nx_dur   = tmg[4*int'(nx_guest)+2 +: 2];
  assign nx_rec   = tmg[4*int'(nx_guest) +: 2];

  assign gb_strobe = (state == S_STROBE);
  assign gb_cs     = gb_strobe ? (NG'(1) << cur_guest) : '0;
  assign busy      = (state != S_IDLE) | hp_valid | cp_valid;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) begin
      cfg_rdata[CMD_LSB +: GW] = cmd_guest;
      cfg_rdata[0 +: AW]       = cmd_addr;
    end else begin
      cfg_rdata[TW-1:0] = tmg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmg       <= '0;
      cmd_guest <= GW'(CMD_GUEST_RST);
      cmd_addr  <= '0;
      state     <= S_IDLE;
      cnt       <= '0;
      cur_rec   <= '0;
      cur_cmd   <= 1'b0;
      cur_guest <= '0;
      gb_write  <= 1'b0;
      gb_addr   <= '0;
      gb_dout   <= '0;
      hp_valid  <= 1'b0;
      hp_write  <= 1'b0;
      hp_guest  <= '0;
      hp_addr   <= '0;
      hp_wdata  <= '0;
      cp_valid  <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      cmd_done  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      cmd_done <= 1'b0;

      if (cfg_we) begin
        if (cfg_sel) begin
          cmd_guest <= cfg_wdata[CMD_LSB +: GW];
          cmd_addr  <= cfg_wdata[0 +: AW];
        end else begin
          tmg <= cfg_wdata[TW-1:0];
        end
      end

      if (req_valid && !hp_valid) begin
        hp_valid <= 1'b1;
        hp_write <= req_write;
        hp_guest <= req_guest;
        hp_addr  <= req_addr;
        hp_wdata <= req_wdata;
      end
      if (cmd_go && !cp_valid)
        cp_valid <= 1'b1;

      case (state)
        S_IDLE: begin
          if (cp_valid || hp_valid) begin
            state     <= S_STROBE;
            cnt       <= code_clocks(nx_dur) - 4'd1;
            cur_rec   <= nx_rec;
            cur_guest <= nx_guest;
            cur_cmd   <= cp_valid;
            if (cp_valid) begin
              cp_valid <= 1'b0;
              gb_write <= 1'b1;
              gb_addr  <= cmd_addr;
              gb_dout  <= '0;
            end else begin
              hp_valid <= 1'b0;
              gb_write <= hp_write;
              gb_addr  <= hp_addr;
              gb_dout  <= hp_wdata;
            end
          end
        end
        S_STROBE: begin
          if (cnt == 4'd0) begin
            state <= S_RECOVER;
            cnt   <= code_clocks(cur_rec) - 4'd1;
            if (!gb_write) begin
              rd_data  <= gb_din;
              rd_valid <= 1'b1;
            end
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        S_RECOVER: begin
          if (cnt == 4'd0) begin
            state    <= S_IDLE;
            cmd_done <= cur_cmd;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/guest_bus_seq_chk.sv
module guest_bus_seq_chk #(
  parameter int NG = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NG-1:0] gb_cs,
  input logic          gb_strobe,
  input logic          gb_write,
  input logic [AW-1:0] gb_addr,
  input logic          rd_valid,
  input logic          cmd_done,
  input logic          busy
);
  // R3
  select_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gb_strobe |-> $countones(gb_cs) == 1);

  // R3
  select_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gb_strobe |-> gb_cs == '0);

  // R3
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gb_strobe && $past(gb_strobe)) |->
      ($stable(gb_cs) && $stable(gb_addr) && $stable(gb_write)));

  // R6
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gb_strobe |-> busy);

  // R2
  recover_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gb_strobe) |-> busy);

  // R4
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(gb_strobe) && !gb_strobe && !$past(gb_write)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!gb_strobe && $past(busy) && !$past(cmd_done)));
endmodule

bind guest_bus_seq guest_bus_seq_chk #(.NG(NG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gb_cs(gb_cs), .gb_strobe(gb_strobe),
  .gb_write(gb_write), .gb_addr(gb_addr), .rd_valid(rd_valid),
  .cmd_done(cmd_done), .busy(busy)
);

// File: tb/test_guest_bus_seq.sv
module test_guest_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_guest = '0, req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        cmd_go = 1'b0;
  logic [7:0]  gb_cs;
  logic        gb_strobe, gb_write;
  logic [2:0]  gb_addr;
  logic [7:0]  gb_dout, gb_din = '0, rd_data;
  logic        rd_valid, cmd_done, busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  guest_bus_seq i_guest_bus_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_guest(req_guest), .req_addr(req_addr),
    .req_wdata(req_wdata), .cmd_go(cmd_go), .gb_cs(gb_cs),
    .gb_strobe(gb_strobe), .gb_write(gb_write), .gb_addr(gb_addr),
    .gb_dout(gb_dout), .gb_din(gb_din), .rd_data(rd_data),
    .rd_valid(rd_valid), .cmd_done(cmd_done), .busy(busy)
  );

  function automatic int clocks(input int code);
    case (code & 3)
      0: return 3;
      1: return 4;
      2: return 12;
      default: return 15;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input int g, input int a, input bit w, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_guest = 3'(g); req_addr = 3'(a);
    req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Called at a negedge where the strobe is high; returns at the first negedge with it low.
  task automatic measure_strobe(input int g, input int a, input bit w, input logic [7:0] d,
                                output int slen, output logic [7:0] last);
    bit okc = 1'b1;
    slen = 0;
    last = '0;
    while (gb_strobe && slen < 40) begin
      slen++;
      if (gb_cs != 8'(1 << g) || gb_addr != 3'(a) || gb_write != w) okc = 1'b0;
      if (w && gb_dout != d) okc = 1'b0;
      gb_din = 8'(g * 37 + a * 11 + slen * 5 + 1);
      last = gb_din;
      @(negedge clk);
    end
    check(okc, "R3/R5 select, address, direction, data during strobe", int'(gb_cs), 1 << g);
    check(gb_cs == 8'd0, "R3 select low after strobe", int'(gb_cs), 0);
  endtask

  task automatic count_busy(output int rlen);
    rlen = 0;
    while (busy && !gb_strobe && rlen < 40) begin
      rlen++;
      @(negedge clk);
    end
  endtask

  task automatic host_cycle(input int g, input int a, input bit w, input logic [7:0] d,
                            input int dexp, input int rexp);
    int slen, rlen;
    logic [7:0] last;
    issue(g, a, w, d);
    check(busy && !gb_strobe, "R6 busy before strobe", int'(busy), 1);
    @(negedge clk);
    check(gb_strobe, "R6 strobe one clock after busy", int'(gb_strobe), 1);
    measure_strobe(g, a, w, d, slen, last);
    check(slen == dexp, "R1 strobe length", slen, dexp);
    if (!w) check(rd_valid && rd_data == last, "R4 read capture", int'(rd_data), int'(last));
    else    check(!rd_valid, "R4 no read pulse on write", int'(rd_valid), 0);
    count_busy(rlen);
    check(rlen == rexp && !busy, "R2 recovery length", rlen, rexp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int slen, rlen, gap;
    bit stayed;
    logic [7:0] last;
    logic [31:0] t;

    repeat (3) @(negedge clk);
    check(!busy && gb_cs == 0 && !gb_strobe, "R10 idle after reset", int'(busy), 0);
    cfg_sel = 1'b0; #1;
    check(cfg_rdata == 32'h0, "R10 timing reset", int'(cfg_rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 32'h40, "R10 command reset", int'(cfg_rdata), 32'h40);

    // R9 go cycle with reset configuration: guest 4, address 0, 3/3 clocks
    @(negedge clk); cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0;
    @(negedge clk);
    measure_strobe(4, 0, 1'b1, 8'h00, slen, last);
    check(slen == 3, "R9 go strobe length default", slen, 3);
    count_busy(rlen);
    check(rlen == 3 && cmd_done, "R9 go done after recovery", rlen, 3);
    @(negedge clk);
    check(!cmd_done, "R9 done is one pulse", int'(cmd_done), 0);

    // R10 reserved bits of the command register read zero
    cfg_write(1'b1, 32'hFFFF_FFFF);
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 32'h77, "R10 reserved bits zero", int'(cfg_rdata), 32'h77);

    // R9 go to guest 6 address 5 with codes 3/1
    cfg_write(1'b1, 32'h65);
    cfg_write(1'b0, 32'h0D00_0000);
    @(negedge clk); cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0;
    @(negedge clk);
    measure_strobe(6, 5, 1'b1, 8'h00, slen, last);
    check(slen == 15, "R9 go uses guest timing", slen, 15);
    count_busy(rlen);
    check(rlen == 4 && cmd_done, "R9 go recovery and done", rlen, 4);

    // R1 R2 R3 R4 R5 sweep of every code on every guest
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        t = '0;
        for (int g = 0; g < 8; g++)
          t[4*g +: 4] = 4'((((g + k) & 3) << 2) | ((g + j) & 3));
        cfg_write(1'b0, t);
        cfg_sel = 1'b0; #1;
        check(cfg_rdata == t, "R10 timing readback", int'(cfg_rdata), int'(t));
        for (int g = 0; g < 8; g++)
          host_cycle(g, (g + k) & 7, 1'((g + k + j) & 1), 8'(g * 16 + k * 4 + j + 1),
                     clocks(g + k), clocks(g + j));
      end
    end

    // R7 R8 pending request, and a third request while the slot is full
    t = '0;
    t[8 +: 4]  = 4'b0110;
    t[12 +: 4] = 4'b0000;
    t[20 +: 4] = 4'b0000;
    cfg_write(1'b0, t);
    issue(2, 1, 1'b1, 8'hA5);
    @(negedge clk);
    issue(3, 2, 1'b0, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_guest = 3'd5; req_addr = 3'd7; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (gb_strobe) @(negedge clk);
    gap = 0; stayed = 1'b1;
    while (!gb_strobe && gap < 40) begin
      if (!busy) stayed = 1'b0;
      gap++;
      @(negedge clk);
    end
    check(gap == 13 && stayed, "R7 pending start after recovery", gap, 13);
    check(gb_cs == 8'h08 && gb_addr == 3'd2, "R7 pending target", int'(gb_cs), 8);
    measure_strobe(3, 2, 1'b0, 8'h00, slen, last);
    check(slen == 3 && rd_data == last, "R7 pending read", int'(rd_data), int'(last));
    count_busy(rlen);
    stayed = 1'b1;
    repeat (25) begin
      if (gb_strobe || busy) stayed = 1'b0;
      @(negedge clk);
    end
    check(stayed, "R8 request with full slot ignored", int'(stayed), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule